// File: doc/BRIEF.md
# Serial Port with Synchronous Shift Mode

This block is a full-duplex serial port for a microcontroller-class subsystem. It has one transmit shift path and a receiver with a holding register. It offers one clocked shift mode and three start/stop framed modes. In the clocked mode the block drives a shift clock on the transmit pin and moves eight data bits, LSB first, over the receive pin. The receive pin becomes bidirectional for that mode. In the framed modes a programmable baud tick sets the bit rate. Each bit lasts sixteen ticks, and the receiver decides every bit by a majority vote of three samples taken around mid-bit.

Software writes a 4-bit control word, a transmit byte and the baud divisor. It reads the received byte from `rx_data_o` and the flags from `status_o`. A read strobe on the status register clears the two done flags. A flag that is raised in the same cycle as the read strobe is kept, so no event is lost.

Control word: bits [1:0] select the mode (0 clocked shift, 1 eight-bit framed, 2 nine-bit framed, 3 nine-bit framed with even parity). Bit [2] enables reception. Bit [3] is the ninth transmit bit in mode 2. Status: bit [0] transmit done, bit [1] receive done, bit [2] received ninth bit (mode 2) or parity error (mode 3), bit [3] busy.

Top module: `uart_sync_port`

## Requirements
- R1: After reset `status_o` is 0, `txd_o` and `rxd_o` are 1, and `rxd_oe_o` is 0.
- R2: In mode 1 a transmit write sends a low start bit, then the 8 data bits LSB first, then a high stop bit. Each bit lasts 16 baud ticks, and one tick comes every `baud_div_i`+1 clocks. The line idles high, and `status_o[0]` sets when the stop bit ends.
- R3: In mode 2 the ninth bit, sent between data bit 7 and the stop bit, is control bit [3]. In mode 3 it is the even parity of the 8 data bits.
- R4: With reception enabled in a framed mode, a frame on `rxd_i` lands in `rx_data_o` and sets `status_o[1]`.
- R5: In mode 2 `status_o[2]` holds the received ninth bit. In mode 3 it is 1 exactly when the received ninth bit differs from the even parity of the received data.
- R6: `rx_data_o` keeps the previous byte while the next frame is being received. It changes only when that frame completes.
- R7: In mode 0 a transmit write sends 8 bits on `rxd_o` with `rxd_oe_o` high. `txd_o` carries the shift clock: a period of 8 clocks, low for 4 and then high for 4, idle high. Each data bit changes 2 clocks after a rising shift-clock edge, and the first bit is valid before the first rise.
- R8: In mode 0, a control write with mode 0 and bit [2] set receives 8 bits from `rxd_i`, LSB first. Each bit is sampled at a rising edge of the shift clock, and the byte then sets `status_o[1]`.
- R9: A status read strobe clears `status_o[0]` and `status_o[1]` on the next cycle.
- R10: A done flag raised in the same cycle as a status read strobe stays set after that read.
- R11: A transmit write while the transmitter is busy is ignored: no second frame is sent.
- R12: A low pulse on `rxd_i` that does not reach the mid-bit samples is rejected as a false start and produces no received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (one oscillator period per cycle) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_i | input | 4 | Control word: mode[1:0], rx enable[2], ninth bit[3] |
| baud_div_i | input | DIV_W | Baud tick divisor minus one |
| tx_wr_i | input | 1 | Transmit byte write strobe |
| tx_data_i | input | DATA_W | Transmit byte |
| stat_rd_i | input | 1 | Status read strobe, clears done flags |
| status_o | output | 4 | busy, ninth/parity, rx done, tx done |
| rx_data_o | output | DATA_W | Received byte holding register |
| txd_o | output | 1 | Framed transmit line, or shift clock in mode 0 |
| rxd_i | input | 1 | Framed receive line, or shift data in for mode 0 |
| rxd_o | output | 1 | Shift data out in mode 0 |
| rxd_oe_o | output | 1 | Output enable for the shifted data pin |

## Verification
The bench goes after the exact cycle at which the transmit-done flag rises in shift mode and places a status read in that same cycle. A design that clears on every read would lose that event. In shift mode it samples the clock and data pins on every cycle of a transfer. An off-by-one in the phase counter shows up as a skewed clock or as data that moves before the rising edge. It sends a frame with a wrong parity bit, which a receiver that only stores the ninth bit would miss. It pulses the line low briefly, which a receiver without the mid-bit vote would accept as a frame. It writes a second byte during a transfer, which a design without a busy guard would corrupt or send. It also checks the holding register in the middle of a second frame, which a single-buffered design would already have overwritten.

// File: rtl/uart_sync_pkg.sv
package uart_sync_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'd0,
    MODE_A8    = 2'd1,
    MODE_A9    = 2'd2,
    MODE_A9P   = 2'd3
  } mode_e;

  localparam int OVS      = 16; // baud ticks per framed bit
  localparam int SH_PH    = 8;  // clocks per shift-mode bit
  localparam int SH_HOLD  = 2;  // clocks data holds after the shift clock rises
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q >= div_i);
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_async_tx.sv
module uart_async_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              nine_i,
  input  logic              b9_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int TC_W = $clog2(OVS);
  localparam int FR_W = DATA_W + 3;
  localparam int LC_W = $clog2(FR_W + 1);

  logic [FR_W-1:0] sh_q;
  logic [TC_W-1:0] tc_q;
  logic [LC_W-1:0] left_q;
  logic            busy_q;
  logic            bit_end;

  assign bit_end = busy_q && tick_i && (tc_q == TC_W'(OVS - 1));
  assign done_o  = bit_end && (left_q == LC_W'(1));
  assign line_o  = busy_q ? sh_q[0] : 1'b1;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      tc_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      tc_q   <= '0;
      // stop, ninth (or second stop), data, start
      sh_q   <= {1'b1, (nine_i ? b9_i : 1'b1), data_i, 1'b0};
      left_q <= nine_i ? LC_W'(FR_W) : LC_W'(FR_W - 1);
    end else if (busy_q && tick_i) begin
      tc_q <= tc_q + 1'b1;
      if (bit_end) begin
        sh_q   <= {1'b1, sh_q[FR_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == LC_W'(1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_async_rx.sv
module uart_async_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              nine_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              b9_o
);
  localparam int TC_W = $clog2(OVS);
  localparam int LB_W = $clog2(DATA_W + 3);
  localparam int MID  = OVS / 2;

  logic [2:0]        sync_q;
  logic              line, fall;
  logic              act_q;
  logic [TC_W-1:0]   tc_q;
  logic [LB_W-1:0]   bidx_q, stop_idx;
  logic [1:0]        vote_q;
  logic [DATA_W-1:0] sh_q;
  logic              b9_q, valid_q;
  logic              samp, decide, bitv;

  assign line     = sync_q[1];
  assign fall     = sync_q[2] && !sync_q[1];
  assign stop_idx = nine_i ? LB_W'(DATA_W + 2) : LB_W'(DATA_W + 1);
  assign samp     = act_q && tick_i && (tc_q >= TC_W'(MID - 1)) && (tc_q <= TC_W'(MID + 1));
  assign decide   = act_q && tick_i && (tc_q == TC_W'(MID + 1));
  // majority of three mid-bit samples
  assign bitv     = (vote_q[1] & vote_q[0]) | (vote_q[1] & line) | (vote_q[0] & line);

  assign valid_o = valid_q;
  assign data_o  = sh_q;
  assign b9_o    = b9_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[1:0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      tc_q    <= '0;
      bidx_q  <= '0;
      vote_q  <= '0;
      sh_q    <= '0;
      b9_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_i) begin
        act_q <= 1'b0;
      end else if (!act_q) begin
        if (fall) begin
          act_q  <= 1'b1;
          tc_q   <= '0;
          bidx_q <= '0;
        end
      end else if (tick_i) begin
        tc_q <= tc_q + 1'b1;
        if (samp) vote_q <= {vote_q[0], line};
        if (decide) begin
          if (bidx_q == '0) begin
            if (bitv) act_q <= 1'b0;   // false start
          end else if (bidx_q <= LB_W'(DATA_W)) begin
            sh_q <= {bitv, sh_q[DATA_W-1:1]};
          end else if (bidx_q == stop_idx) begin
            valid_q <= 1'b1;
            act_q   <= 1'b0;
          end else begin
            b9_q <= bitv;
          end
        end
        if (tc_q == TC_W'(OVS - 1)) bidx_q <= bidx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_shift_unit.sv
module uart_shift_unit #(
  parameter int DATA_W = 8,
  parameter int PH     = 8,
  parameter int HOLD   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_tx_i,
  input  logic              start_rx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rxd_i,
  output logic              sclk_o,
  output logic              dout_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int PH_W = $clog2(PH);
  localparam int SL_W = $clog2(DATA_W);
  localparam int HALF = PH / 2;
  localparam int CHG  = HALF + HOLD;

  logic              busy_q, dir_tx_q, dout_q;
  logic [PH_W-1:0]   ph_q;
  logic [SL_W-1:0]   sl_q;
  logic [DATA_W-1:0] txsh_q, rxsh_q;
  logic              last;

  assign last      = busy_q && (ph_q == PH_W'(PH - 1)) && (sl_q == SL_W'(DATA_W - 1));
  assign sclk_o    = !busy_q || (ph_q >= PH_W'(HALF));
  assign dout_o    = dout_q;
  assign oe_o      = busy_q && dir_tx_q;
  assign busy_o    = busy_q;
  assign tx_done_o = last && dir_tx_q;
  assign rx_done_o = last && !dir_tx_q;
  assign rx_byte_o = rxsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      dir_tx_q <= 1'b0;
      dout_q   <= 1'b1;
      ph_q     <= '0;
      sl_q     <= '0;
      txsh_q   <= '0;
      rxsh_q   <= '0;
    end else if (!busy_q) begin
      if (start_tx_i || start_rx_i) begin
        busy_q   <= 1'b1;
        dir_tx_q <= start_tx_i;
        ph_q     <= '0;
        sl_q     <= '0;
        txsh_q   <= data_i;
        dout_q   <= start_tx_i ? data_i[0] : 1'b1;
      end
    end else begin
      if (ph_q == PH_W'(PH - 1)) begin
        ph_q <= '0;
        sl_q <= sl_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
      // next bit appears HOLD clocks after the rising edge
      if (dir_tx_q && (ph_q == PH_W'(CHG - 1)) && (sl_q != SL_W'(DATA_W - 1))) begin
        dout_q <= txsh_q[1];
        txsh_q <= txsh_q >> 1;
      end
      // sample on the edge where the shift clock rises
      if (!dir_tx_q && (ph_q == PH_W'(HALF - 1)))
        rxsh_q <= {rxd_i, rxsh_q[DATA_W-1:1]};
      if (last) begin
        busy_q <= 1'b0;
        dout_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_sync_port.sv
module uart_sync_port
  import uart_sync_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [3:0]        ctrl_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              stat_rd_i,
  output logic [3:0]        status_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rxd_o,
  output logic              rxd_oe_o
);
  logic [3:0]        ctrl_q;
  mode_e             mode;
  logic              shift_mode, nine;
  logic              tick;
  logic              atx_line, atx_busy, atx_done;
  logic              arx_valid, arx_b9;
  logic [DATA_W-1:0] arx_data;
  logic              sh_sclk, sh_dout, sh_oe, sh_busy, sh_tx_done, sh_rx_done;
  logic [DATA_W-1:0] sh_rx_byte;
  logic              start_rx_sh;
  logic              tx_set, rx_set;
  logic              tx_flag_q, rx_flag_q, rb8_q;
  logic [DATA_W-1:0] rx_hold_q;

  assign mode        = mode_e'(ctrl_q[1:0]);
  assign shift_mode  = (mode == MODE_SHIFT);
  assign nine        = (mode == MODE_A9) || (mode == MODE_A9P);
  assign start_rx_sh = ctrl_wr_i && (ctrl_i[1:0] == MODE_SHIFT) && ctrl_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_i;
  end

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(!shift_mode),
    .div_i (baud_div_i), .tick_o(tick)
  );

  uart_async_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_atx (
    .clk_i  (clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(tx_wr_i && !shift_mode),
    .data_i (tx_data_i), .nine_i(nine),
    .b9_i   ((mode == MODE_A9P) ? ^tx_data_i : ctrl_q[3]),
    .line_o (atx_line), .busy_o(atx_busy), .done_o(atx_done)
  );

  uart_async_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_arx (
    .clk_i  (clk_i), .rst_ni(rst_ni), .en_i(ctrl_q[2] && !shift_mode),
    .tick_i (tick), .rxd_i(rxd_i), .nine_i(nine),
    .valid_o(arx_valid), .data_o(arx_data), .b9_o(arx_b9)
  );

  uart_shift_unit #(.DATA_W(DATA_W), .PH(SH_PH), .HOLD(SH_HOLD)) u_shift (
    .clk_i     (clk_i), .rst_ni(rst_ni),
    .start_tx_i(tx_wr_i && shift_mode), .start_rx_i(start_rx_sh),
    .data_i    (tx_data_i), .rxd_i(rxd_i),
    .sclk_o    (sh_sclk), .dout_o(sh_dout), .oe_o(sh_oe), .busy_o(sh_busy),
    .tx_done_o (sh_tx_done), .rx_done_o(sh_rx_done), .rx_byte_o(sh_rx_byte)
  );

  assign tx_set = atx_done || sh_tx_done;
  assign rx_set = arx_valid || sh_rx_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_flag_q <= 1'b0;
      rx_flag_q <= 1'b0;
      rb8_q     <= 1'b0;
      rx_hold_q <= '0;
    end else begin
      // a set in the read cycle wins over the clear
      tx_flag_q <= tx_set || (tx_flag_q && !stat_rd_i);
      rx_flag_q <= rx_set || (rx_flag_q && !stat_rd_i);
      if (arx_valid) begin
        rx_hold_q <= arx_data;
        unique case (mode)
          MODE_A9P: rb8_q <= arx_b9 ^ (^arx_data);
          MODE_A9:  rb8_q <= arx_b9;
          default:  rb8_q <= 1'b0;
        endcase
      end else if (sh_rx_done) begin
        rx_hold_q <= sh_rx_byte;
        rb8_q     <= 1'b0;
      end
    end
  end

  assign status_o  = {(atx_busy || sh_busy), rb8_q, rx_flag_q, tx_flag_q};
  assign rx_data_o = rx_hold_q;
  assign txd_o     = shift_mode ? sh_sclk : atx_line;
  assign rxd_o     = shift_mode ? sh_dout : 1'b1;
  assign rxd_oe_o  = shift_mode && sh_oe;
endmodule

// File: rtl/uart_sync_port_chk.sv
module uart_sync_port_chk
  import uart_sync_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stat_rd_i,
  input logic [3:0] status_o,
  input logic       txd_o,
  input logic       rxd_o,
  input logic       shift_mode,
  input logic       sh_busy,
  input logic       atx_busy,
  input logic       tx_set,
  input logic       rx_set
);
  logic [3:0] lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   lo_cnt_q <= '0;
    else if (shift_mode && !txd_o) lo_cnt_q <= lo_cnt_q + 1'b1;
    else                           lo_cnt_q <= '0;
  end

  AST_ASYNC_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_mode && !atx_busy) |-> txd_o); // R2

  AST_SHIFT_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_mode && sh_busy && $rose(txd_o)) |=> $stable(rxd_o)); // R7

  AST_SHIFT_LOW_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_cnt_q <= 4'(SH_PH / 2)); // R7

  AST_TX_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_set && stat_rd_i) |=> status_o[0]); // R10

  AST_RX_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_set && stat_rd_i) |=> status_o[1]); // R10

  AST_TX_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !tx_set) |=> !status_o[0]); // R9
endmodule

bind uart_sync_port uart_sync_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stat_rd_i (stat_rd_i),
  .status_o  (status_o),
  .txd_o     (txd_o),
  .rxd_o     (rxd_o),
  .shift_mode(shift_mode),
  .sh_busy   (sh_busy),
  .atx_busy  (atx_busy),
  .tx_set    (tx_set),
  .rx_set    (rx_set)
);

// File: tb/uart_sync_port_bench.sv
module uart_sync_port_bench;
  localparam int CLK_P = 10;
  localparam int DIV   = 3;
  localparam int BIT   = 16 * (DIV + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0, tx_wr = 1'b0, stat_rd = 1'b0;
  logic [3:0]  ctrl = '0;
  logic [7:0]  tx_data = '0;
  logic [3:0]  status;
  logic [7:0]  rx_data;
  logic        txd, rxd_out, rxd_oe;
  logic        loop_en = 1'b0, drv_rxd = 1'b1;
  logic        rxd_line;
  int          n_chk = 0, n_fail = 0;

  assign rxd_line = loop_en ? txd : drv_rxd;
  always #(CLK_P / 2) clk = ~clk;

  uart_sync_port u_uart_sync_port (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_i(ctrl),
    .baud_div_i(12'(DIV)), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .stat_rd_i(stat_rd), .status_o(status), .rx_data_o(rx_data),
    .txd_o(txd), .rxd_i(rxd_line), .rxd_o(rxd_out), .rxd_oe_o(rxd_oe)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input int md, input logic b9);
    logic ninth;
    ninth = (md == 3) ? ^d : ((md == 2) ? b9 : 1'b1);
    return {1'b1, ninth, d, 1'b0};
  endfunction

  task automatic set_ctrl(input logic [3:0] c);
    @(negedge clk); ctrl_wr = 1'b1; ctrl = c;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic wait_flag(input int idx, output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 4000 && !ok; i++) begin
      @(negedge clk);
      ok = status[idx];
    end
  endtask

  task automatic capture(input int n, output logic [10:0] f);
    f = '1;
    for (int i = 0; i < 5000 && txd; i++) @(negedge clk);
    repeat (BIT / 2) @(negedge clk);
    f[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (BIT) @(negedge clk);
      f[i] = txd;
    end
  endtask

  task automatic send_frame(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      drv_rxd = f[i];
      repeat (BIT) @(negedge clk);
    end
    drv_rxd = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (R1 run incomplete)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [10:0] f, e;
    logic [7:0]  d, a, b;
    logic        ok, b9;
    int          errs_c, errs_d, errs_oe, lows;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk(status == 4'h0, "R1 status", status, 0);
    chk(txd && rxd_out && !rxd_oe, "R1 pins", {txd, rxd_out, rxd_oe}, 3'b110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // framed modes in loopback
    loop_en = 1'b1;
    for (int md = 1; md <= 3; md++) begin
      for (int k = 0; k < 3; k++) begin
        d  = 8'($urandom);
        b9 = 1'($urandom);
        set_ctrl({b9, 1'b1, 2'(md)});
        tx_write(d);
        capture((md == 1) ? 10 : 11, f);
        e = exp_frame(d, md, b9);
        chk(f == e, (md == 1) ? "R2 frame" : "R3 ninth bit frame", f, e);
        wait_flag(1, ok);
        chk(ok && rx_data == d, "R4 loopback byte", rx_data, d);
        if (md == 2) chk(status[2] == b9, "R5 ninth bit", status[2], b9);
        if (md == 3) chk(status[2] == 1'b0, "R5 parity ok", status[2], 0);
        wait_flag(0, ok);
        chk(ok, "R2 tx done", status[0], 1);
        rd_status();
        chk(status[1:0] == 2'b00, "R9 clear", status[1:0], 0);
      end
    end

    // R11: second write during a transfer
    set_ctrl(4'b0101);
    a = 8'h3C; b = 8'hA5;
    tx_write(a);
    fork
      capture(10, f);
      begin repeat (100) @(negedge clk); tx_write(b); end
    join
    e = exp_frame(a, 1, 1'b0);
    chk(f == e, "R11 first frame intact", f, e);
    lows = 0;
    repeat (BIT) @(negedge clk);
    repeat (3 * BIT) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, "R11 no second frame", lows, 0);
    rd_status();

    // R6: double buffer
    loop_en = 1'b0;
    a = 8'($urandom); b = ~a;
    send_frame(exp_frame(a, 1, 1'b0), 10);
    wait_flag(1, ok);
    chk(ok && rx_data == a, "R6 first byte", rx_data, a);
    rd_status();
    f = exp_frame(b, 1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      drv_rxd = f[i];
      if (i == 5) chk(rx_data == a, "R6 held during next frame", rx_data, a);
      repeat (BIT) @(negedge clk);
    end
    drv_rxd = 1'b1;
    wait_flag(1, ok);
    chk(ok && rx_data == b, "R6 second byte", rx_data, b);
    rd_status();

    // R12: short low pulse
    drv_rxd = 1'b0;
    repeat (6) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    chk(status[1] == 1'b0, "R12 glitch rejected", status[1], 0);
    d = 8'h5A;
    send_frame(exp_frame(d, 1, 1'b0), 10);
    wait_flag(1, ok);
    chk(ok && rx_data == d, "R12 receive after glitch", rx_data, d);
    rd_status();

    // R5: bad parity in mode 3
    set_ctrl(4'b0111);
    d = 8'($urandom);
    send_frame({1'b1, ~(^d), d, 1'b0}, 11);
    wait_flag(1, ok);
    chk(ok && status[2] == 1'b1, "R5 parity error", status[2], 1);
    chk(rx_data == d, "R5 data with parity error", rx_data, d);
    rd_status();

    // R7: shift mode transmit, per-cycle pin check
    set_ctrl(4'b0000);
    d = 8'($urandom);
    errs_c = 0; errs_d = 0; errs_oe = 0;
    tx_write(d);
    for (int j = 0; j < 64; j++) begin
      int s, p;
      logic exp_d;
      s = j / 8; p = j % 8;
      exp_d = (p >= 6 && s < 7) ? d[s + 1] : d[s];
      if (txd != (p >= 4)) errs_c++;
      if (rxd_out != exp_d) errs_d++;
      if (!rxd_oe) errs_oe++;
      @(negedge clk);
    end
    chk(errs_c == 0, "R7 shift clock shape", errs_c, 0);
    chk(errs_d == 0, "R7 shift data timing", errs_d, 0);
    chk(errs_oe == 0, "R7 output enable", errs_oe, 0);
    chk(txd && !rxd_oe && status[0], "R7 end of transfer", {txd, rxd_oe, status[0]}, 3'b101);
    rd_status();

    // R10: read in the cycle the flag sets
    d = 8'($urandom);
    tx_write(d);
    repeat (63) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk(status[0] == 1'b1, "R10 flag kept", status[0], 1);
    rd_status();
    chk(status[0] == 1'b0, "R9 later read clears", status[0], 0);

    // R8: shift mode receive
    d = 8'($urandom);
    drv_rxd = d[0];
    set_ctrl(4'b0100);
    drv_rxd = d[0];
    for (int j = 1; j < 64; j++) begin
      @(negedge clk);
      drv_rxd = d[j / 8];
    end
    @(negedge clk);
    chk(status[1] == 1'b1, "R8 rx done", status[1], 1);
    chk(rx_data == d, "R8 shift byte", rx_data, d);
    drv_rxd = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule